// File: doc/BRIEF.md
# Flash Status Polling Checker

This block runs on the host side of a parallel flash interface and decides whether a program or erase operation has completed and succeeded. A start pulse hands it the address to poll, the data that was written and whether the operation was an erase. It then reads that address repeatedly through a request/acknowledge read port. Each returned word is judged on two status bits: bit 7, which takes on the true value of the written data once the operation is over, and bit 5, which the device raises when it has run past its internal limit.

A mismatch on bit 7 with bit 5 low means the device is still working, so the block reads again after a programmable number of idle cycles. A mismatch with bit 5 high is not yet a failure. Bit 7 can settle in the same cycle that bit 5 rises, so the block reads the same address once more and judges that read alone. An optional read budget ends a poll that has gone on too long with a failure. The result appears as a one-cycle done pulse with a pass flag that stays valid until the next poll is started.

The caller must pick a valid poll address. For a program operation this is the programmed location. For a sector erase it is any address inside that sector. For a chip erase it is any address in a sector that is not protected.

Top module: `status_poll_checker`

## Requirements
- R1: Every read request issued during a poll carries the address latched at the accepted start, and that address stays stable while a request waits for its acknowledge.
- R2: `rd_req` stays high from the cycle it rises until the cycle in which `rd_ack` is sampled high. It is never high while `busy` is low.
- R3: The expected status value is bit 7 of `expect_data` for a program and 1 for an erase (`is_erase` = 1). A read whose bit 7 equals that value ends the poll with pass = 1.
- R4: A read whose bit 7 differs and whose bit 5 is 0 leads to another read of the same address, unless R7 ends the poll.
- R5: A read whose bit 7 differs and whose bit 5 is 1 leads to exactly one more read. If bit 7 of that read matches, the poll passes. Otherwise it fails, whatever bit 5 shows.
- R6: Between an acknowledged read and the next request, `rd_req` is low for exactly `gap_cycles` cycles. With 0, the next request follows at once.
- R7: With `timeout_en` = 1, a read that leaves the poll undecided and brings the read count to `max_reads` ends the poll with pass = 0. A `max_reads` of 0 acts as 1. A recheck started by R5 is always carried out. With `timeout_en` = 0 the number of reads is unlimited.
- R8: `done` is high for exactly one cycle, the cycle after the deciding acknowledge, and `busy` is low in that cycle. `pass` holds its value until the next accepted start.
- R9: A `start` that arrives while `busy` is high is ignored. The address, expected value and result of the running poll do not change.
- R10: After reset, `busy`, `done`, `pass` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a poll; accepted only when idle |
| target_addr | input | ADDR_W | Address to poll |
| expect_data | input | DATA_W | Data that was programmed; bit 7 is the reference |
| is_erase | input | 1 | 1: erase operation, expected bit 7 is 1 |
| gap_cycles | input | GAP_W | Idle cycles between reads |
| timeout_en | input | 1 | Enable the read budget |
| max_reads | input | CNT_W | Read budget when enabled |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid with it |
| rd_data | input | DATA_W | Read data |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last poll |

## Verification
The embedded assertions assume that `rd_ack` is raised only while `rd_req` is high and only for one cycle per request. They also assume that the configuration inputs are sampled only at an accepted start. The bench's responder returns an acknowledge after a random latency and drops it in the following cycle, so it never acknowledges an idle port or the same request twice. Configuration and start are driven away from the clock edge. Random polls draw their status words so that bit 5 appears on some mismatching reads and a matching word eventually arrives. Directed cases push the recheck, budget and busy-start paths to their edges.

// File: rtl/poll_pkg.sv
// Package: shared types for the status polling checker.
// Assumes: nothing beyond IEEE 1800-2017.
package poll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } poll_state_t;

    typedef enum logic [1:0] {
        V_CONTINUE = 2'd0,
        V_RECHECK  = 2'd1,
        V_PASS     = 2'd2,
        V_FAIL     = 2'd3
    } poll_verdict_t;

endpackage

// File: rtl/poll_decide.sv
// Module: judges one returned status word.
// Assumes: inputs are meaningful only in the acknowledge cycle. Priority:
// bit-7 match, then an armed recheck, then bit 5, then the read budget.
module poll_decide
    import poll_pkg::*;
(
    input  logic          stat_bit,
    input  logic          limit_bit,
    input  logic          expect_bit,
    input  logic          recheck_armed,
    input  logic          budget_spent,
    output poll_verdict_t verdict
);

    // Combinational verdict for the current read.
    always_comb begin
        if (stat_bit == expect_bit)  verdict = V_PASS;
        else if (recheck_armed)      verdict = V_FAIL;
        else if (limit_bit)          verdict = V_RECHECK;
        else if (budget_spent)       verdict = V_FAIL;
        else                         verdict = V_CONTINUE;
    end

endmodule

// File: rtl/poll_gap_timer.sv
// Module: counts the idle cycles inserted between reads.
// Assumes: load is only pulsed with a non-zero value; tick is high while
// the controller waits in its gap state.
module poll_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);

    logic [GAP_W-1:0] cnt_q;

    // Load on a new gap, count down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load)     cnt_q <= load_val;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == {{(GAP_W-1){1'b0}}, 1'b1});

    AST_GAP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> cnt_q != '0) else $error("gap counter empty while waiting"); // R6

endmodule

// File: rtl/poll_read_budget.sv
// Module: counts acknowledged reads of one poll and flags the budget.
// Assumes: clear is pulsed at each accepted start; inc at each acknowledge.
module poll_read_budget #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             spent
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] reads_q;
    logic [CNT_W:0]   limit_eff;
    logic [CNT_W:0]   reads_next;

    // Count reads, saturating at the counter maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                        reads_q <= '0;
        else if (clear)                    reads_q <= '0;
        else if (inc && reads_q != CNT_MAX) reads_q <= reads_q + 1'b1;
    end

    // The current read would bring the count to the limit (0 acts as 1).
    always_comb begin
        limit_eff  = (limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit};
        reads_next = {1'b0, reads_q} + 1'b1;
        spent      = enable && (reads_next >= limit_eff);
    end

    AST_BUDGET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> reads_q == '0) else $error("read count not cleared"); // R7

endmodule

// File: rtl/status_poll_checker.sv
// Module: polls one flash address until bit 7 reports the written value,
// rechecking once after bit 5 rises, and reports pass or fail.
// Assumes: rd_ack only while rd_req is high, one acknowledge per request.
module status_poll_checker
    import poll_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16,
    parameter int GAP_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [DATA_W-1:0] expect_data,
    input  logic              is_erase,
    input  logic [GAP_W-1:0]  gap_cycles,
    input  logic              timeout_en,
    input  logic [CNT_W-1:0]  max_reads,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass
);

    localparam int STAT_BIT  = 7;
    localparam int LIMIT_BIT = 5;

    poll_state_t      state_q;
    logic [ADDR_W-1:0] addr_q;
    logic             expect_q;
    logic [GAP_W-1:0] gap_q;
    logic             ten_q;
    logic [CNT_W-1:0] max_q;
    logic             recheck_q;
    logic             done_q;
    logic             pass_q;

    logic             accept;
    logic             read_taken;
    logic             gap_last;
    logic             budget_spent;
    poll_verdict_t    verdict;

    assign accept     = (state_q == ST_IDLE) && start;
    assign read_taken = (state_q == ST_ISSUE) && rd_ack;

    poll_decide u_decide (
        .stat_bit      (rd_data[STAT_BIT]),
        .limit_bit     (rd_data[LIMIT_BIT]),
        .expect_bit    (expect_q),
        .recheck_armed (recheck_q),
        .budget_spent  (budget_spent),
        .verdict       (verdict)
    );

    poll_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (read_taken && gap_q != '0),
        .load_val (gap_q),
        .tick     (state_q == ST_GAP),
        .last     (gap_last)
    );

    poll_read_budget #(.CNT_W(CNT_W)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .inc    (read_taken),
        .enable (ten_q),
        .limit  (max_q),
        .spent  (budget_spent)
    );

    // Latch the poll setup at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            expect_q <= 1'b0;
            gap_q    <= '0;
            ten_q    <= 1'b0;
            max_q    <= '0;
        end else if (accept) begin
            addr_q   <= target_addr;
            expect_q <= is_erase ? 1'b1 : expect_data[STAT_BIT];
            gap_q    <= gap_cycles;
            ten_q    <= timeout_en;
            max_q    <= max_reads;
        end
    end

    // Polling state machine with result and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            recheck_q <= 1'b0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        recheck_q <= 1'b0;
                        pass_q    <= 1'b0;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (rd_ack) begin
                        unique case (verdict)
                            V_PASS: begin
                                pass_q  <= 1'b1;
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            V_FAIL: begin
                                pass_q  <= 1'b0;
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            V_RECHECK: begin
                                recheck_q <= 1'b1;
                                state_q   <= (gap_q == '0) ? ST_ISSUE : ST_GAP;
                            end
                            default: begin
                                state_q <= (gap_q == '0) ? ST_ISSUE : ST_GAP;
                            end
                        endcase
                    end
                end
                ST_GAP: begin
                    if (gap_last) state_q <= ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_req  = (state_q == ST_ISSUE);
    assign rd_addr = addr_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign pass    = pass_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req) else $error("request dropped"); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req) else $error("request while idle"); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> $stable(rd_addr)) else $error("address moved"); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R8
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(rd_addr)) else $error("start taken while busy"); // R9
    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !done && !start |=> $stable(pass)) else $error("pass changed while idle"); // R8

endmodule

// File: tb/status_poll_checker_bench.sv
module status_poll_checker_bench;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 16;
    localparam int GAP_W  = 8;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] target_addr = '0;
    logic [DATA_W-1:0] expect_data = '0;
    logic              is_erase = 1'b0;
    logic [GAP_W-1:0]  gap_cycles = '0;
    logic              timeout_en = 1'b0;
    logic [CNT_W-1:0]  max_reads = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy, done, pass;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [DATA_W-1:0] script [0:31];
    int idx = 0;
    int lat_max = 0;
    int lat_cnt = 0;
    logic [ADDR_W-1:0] cur_addr = '0;
    int addr_err = 0;
    int gap_err = 0;
    logic gap_track = 1'b0;
    int zero_run = 0;
    int cur_gap = 0;

    always #2 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    status_poll_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_W(GAP_W), .CNT_W(CNT_W))
    u_status_poll_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .target_addr(target_addr),
        .expect_data(expect_data), .is_erase(is_erase), .gap_cycles(gap_cycles),
        .timeout_en(timeout_en), .max_reads(max_reads), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .pass(pass)
    );

    // Responder and gap monitor, acting between clock edges.
    always @(negedge clk) begin
        if (!busy) gap_track = 1'b0;
        if (gap_track) begin
            if (!rd_req) zero_run++;
            else begin
                if (zero_run != cur_gap) gap_err++;
                gap_track = 1'b0;
            end
        end
        if (rd_ack) rd_ack = 1'b0;
        else if (rd_req) begin
            if (lat_cnt == 0) begin
                rd_ack  = 1'b1;
                rd_data = script[(idx < 32) ? idx : 31];
                if (rd_addr != cur_addr) addr_err++;
                idx++;
                lat_cnt = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
                gap_track = 1'b1;
                zero_run  = 0;
            end else lat_cnt--;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference decision from the requirements: returns pass, sets read count.
    function automatic bit model(input bit expb, input bit ten, input int maxr,
                                 output int reads);
        bit armed = 1'b0;
        int lim = (maxr == 0) ? 1 : maxr;
        reads = 0;
        for (int i = 0; i < 32; i++) begin
            reads++;
            if (script[i][7] == expb) return 1'b1;
            if (armed) return 1'b0;
            if (script[i][5]) armed = 1'b1;
            else if (ten && reads >= lim) return 1'b0;
        end
        return 1'b0;
    endfunction

    function automatic logic [DATA_W-1:0] word(input bit b7, input bit b5);
        logic [DATA_W-1:0] w = DATA_W'($urandom);
        w[7] = b7;
        w[5] = b5;
        return w;
    endfunction

    task automatic run_txn(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] ed,
                           input bit er, input int gap, input bit ten, input int maxr,
                           input int latm, input bit poke, input string tag);
        bit expb = er ? 1'b1 : ed[7];
        int exp_reads, dcount, wd;
        bit exp_pass = model(expb, ten, maxr, exp_reads);
        bit pass_seen;
        idx = 0; addr_err = 0; gap_err = 0; lat_max = latm; lat_cnt = 0;
        cur_addr = a; cur_gap = gap;
        target_addr = a; expect_data = ed; is_erase = er;
        gap_cycles = GAP_W'(gap); timeout_en = ten; max_reads = CNT_W'(maxr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", {tag, " busy after start"}, int'(busy), 1);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; target_addr = ~a; expect_data = ~ed; gap_cycles = '0;
            @(negedge clk);
            start = 1'b0;
        end
        dcount = 0; wd = 0;
        while (!done && wd < 3000) begin
            @(negedge clk);
            wd++;
        end
        if (wd >= 3000) begin
            check(1'b0, "R8", {tag, " watchdog"}, wd, 0);
            return;
        end
        pass_seen = pass;
        check(busy == 1'b0, "R8", {tag, " busy low with done"}, int'(busy), 0);
        for (int k = 0; k < 4; k++) begin
            if (done) dcount++;
            @(negedge clk);
        end
        check(dcount == 1, "R8", {tag, " done width"}, dcount, 1);
        check(pass == pass_seen, "R8", {tag, " pass held"}, int'(pass), int'(pass_seen));
        check(pass_seen == exp_pass, "R3", {tag, " verdict"}, int'(pass_seen), int'(exp_pass));
        check(idx == exp_reads, "R5", {tag, " read count"}, idx, exp_reads);
        check(addr_err == 0, "R1", {tag, " read address"}, addr_err, 0);
        check(gap_err == 0, "R6", {tag, " idle gap"}, gap_err, 0);
        check(rd_req == 1'b0, "R2", {tag, " no request when idle"}, int'(rd_req), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !pass && !rd_req, "R10", "reset outputs",
              {28'd0, busy, done, pass, rd_req}, 0);

        // R3: first read matches, no gap.
        for (int i = 0; i < 32; i++) script[i] = word(1'b1, 1'b0);
        run_txn(21'h00123, 16'h0080, 1'b0, 0, 1'b0, 0, 0, 1'b0, "R3 first match");
        // R3: erase expects 1 even though written bit 7 is 0.
        run_txn(21'h1ABCD, 16'h0000, 1'b1, 1, 1'b0, 0, 1, 1'b0, "R3 erase");
        // R4: several busy reads then a match, no budget.
        for (int i = 0; i < 32; i++) script[i] = word(i >= 20, 1'b0);
        run_txn(21'h0F00F, 16'h0080, 1'b0, 2, 1'b0, 0, 1, 1'b0, "R4 long poll");
        // R5: bit 5 then match on recheck.
        script[0] = word(1'b0, 1'b1);
        for (int i = 1; i < 32; i++) script[i] = word(1'b1, 1'b1);
        run_txn(21'h00042, 16'h0080, 1'b0, 3, 1'b0, 0, 2, 1'b0, "R5 recheck pass");
        // R5: bit 5 then mismatch on recheck fails.
        for (int i = 0; i < 32; i++) script[i] = word(1'b0, i == 0);
        run_txn(21'h00043, 16'h0080, 1'b0, 0, 1'b0, 0, 0, 1'b0, "R5 recheck fail");
        // R7: budget of 3 expires.
        for (int i = 0; i < 32; i++) script[i] = word(1'b1, 1'b0);
        run_txn(21'h00044, 16'h0000, 1'b0, 1, 1'b1, 3, 1, 1'b0, "R7 budget");
        // R7: budget 0 acts as 1.
        run_txn(21'h00045, 16'h0000, 1'b0, 0, 1'b1, 0, 0, 1'b0, "R7 zero budget");
        // R7: bit 5 on the last budgeted read still rechecks.
        script[1] = word(1'b1, 1'b1); script[2] = word(1'b0, 1'b0);
        run_txn(21'h00046, 16'h0000, 1'b0, 0, 1'b1, 2, 1, 1'b0, "R7 recheck past budget");
        // R9: start while busy is ignored.
        for (int i = 0; i < 32; i++) script[i] = word(i >= 6, 1'b0);
        run_txn(21'h15555, 16'h0080, 1'b0, 4, 1'b0, 0, 2, 1'b1, "R9 busy start");

        // Random polls.
        for (int t = 0; t < 60; t++) begin
            logic [DATA_W-1:0] ed = DATA_W'($urandom);
            bit er = $urandom % 2;
            bit expb = er ? 1'b1 : ed[7];
            int k = $urandom % 12;
            for (int i = 0; i < 32; i++)
                script[i] = (i >= k) ? word(expb, $urandom % 2)
                                     : word(!expb, ($urandom % 5) == 0);
            run_txn(ADDR_W'($urandom), ed, er, $urandom % 4, $urandom % 2,
                    $urandom % 6, $urandom % 3, ($urandom % 8) == 0, "R4 random");
            if (cycles > 150000) break;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule